// File: doc/BRIEF.md
# Pixel Gain Range Selection Sequencer

This controller decides which of a pixel's three charge-holding nodes carries a usable, non-saturated level. The three nodes are the photodiode and two overflow capacitors of increasing size. After a start pulse it visits the nodes in a fixed order, from the most sensitive to the least. Each node is held selected for a programmable settling window. At the end of that window the single comparator bit is sampled, and the comparator checks the node against one shared threshold. The first node that passes wins. If none passes, the largest capacitor is taken and a saturation flag is raised.

The chosen node is then offered to the converter through a valid/ready request. A 2-bit range code travels with that request so downstream logic knows which gain applies. When the photodiode is chosen and double sampling was enabled at start, two requests are issued. The first, marked as the reference read, is followed by the signal read. The producer side never drops a request. `conv_valid_o` stays high, with `conv_ref_o` and `range_code_o` unchanged, until a cycle in which `conv_ready_i` is high. That cycle completes the transfer.

Top module: `gainrange_seq`

## Requirements
- R1: After reset, `busy_o`, `conv_valid_o`, `conv_ref_o` and `range_sat_o` are 0, `node_sel_o` is 3'b000 and `range_code_o` is 2'b00.
- R2: A run selects nodes through the one-hot `node_sel_o` in the order bit0 (diode), bit1 (small capacitor), bit2 (large capacitor). Each node stays selected for `settle_cycles_i`+1 cycles, and a node is skipped once a selection is made.
- R3: The first node whose comparator sample is 1 is chosen. Its code is 2'b00 for the diode, 2'b01 for the small capacitor and 2'b10 for the large capacitor. Code 2'b11 never appears.
- R4: If no node passes, the code is 2'b10 and `range_sat_o` is 1. A passing selection clears `range_sat_o`.
- R5: `cmp_pass_i` is sampled only in the last cycle of each node's settle window. Its value in earlier cycles has no effect.
- R6: Double sampling happens only when `cds_en_i` was 1 at the accepted start and the diode is chosen. In that case two requests are issued: the first with `conv_ref_o`=1 and the second with `conv_ref_o`=0. Every other case issues one request with `conv_ref_o`=0.
- R7: A request appears one cycle after selection. `conv_valid_o` stays high, with the code and reference flag stable, until a transfer cycle (`conv_valid_o` and `conv_ready_i` both 1).
- R8: `busy_o` rises in the cycle after an accepted start. It falls in the cycle after the final transfer. A start seen while busy, including in the final transfer cycle, is ignored.
- R9: `range_code_o` and `range_sat_o` change only when a selection is made and hold their values in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| cds_en_i | input | 1 | Double-sampling enable, captured at start |
| settle_cycles_i | input | SETTLE_W | Extra settle cycles per node |
| cmp_pass_i | input | 1 | Comparator result for the selected node |
| node_sel_o | output | 3 | One-hot node select strobe |
| conv_valid_o | output | 1 | Conversion request valid |
| conv_ready_i | input | 1 | Converter accepts request |
| conv_ref_o | output | 1 | Request is the reset-level reference read |
| range_code_o | output | 2 | Selected range code |
| range_sat_o | output | 1 | No node passed |
| busy_o | output | 1 | Sequence in progress |

## Verification
The final transfer of a run and a new start can fall in the same cycle. When this happens the start must be dropped while the block returns to idle. The bench holds `start_i` high for the entire busy period, across back-pressured and double-sampled runs. A behavioural reference model then judges every cycle: it expects busy to fall one cycle after the transfer and no new node strobe. The comparator is also driven inverted before each sampling cycle, so any early sampling shows up as a wrong code.

// File: rtl/gr_pkg.sv
package gr_pkg;
  localparam int NODES  = 3;
  localparam int CODE_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_CONV = 2'd2
  } seq_state_e;

  localparam logic [CODE_W-1:0] CODE_DIODE = 2'b00;
  localparam logic [CODE_W-1:0] CODE_CAP_S = 2'b01;
  localparam logic [CODE_W-1:0] CODE_CAP_L = 2'b10;
endpackage

// File: rtl/gr_settle_timer.sv
module gr_settle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt_q;

  assign done = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || done) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gr_range_latch.sv
module gr_range_latch #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] load_code,
  input  logic              load_sat,
  output logic [CODE_W-1:0] code,
  output logic              sat
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code <= '0;
      sat  <= 1'b0;
    end else if (load) begin
      code <= load_code;
      sat  <= load_sat;
    end
  end
endmodule

// File: rtl/gr_seq_fsm.sv
module gr_seq_fsm
  import gr_pkg::*;
#(
  parameter int N = NODES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cds_en,
  input  logic              cmp_pass,
  input  logic              settle_done,
  input  logic              conv_ready,
  output logic              timer_run,
  output logic [N-1:0]      node_sel,
  output logic              conv_valid,
  output logic              conv_ref,
  output logic              busy,
  output logic              load,
  output logic [CODE_W-1:0] load_code,
  output logic              load_sat
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  seq_state_e      state_q, state_d;
  logic [IDX_W-1:0] node_q, node_d;
  logic            cds_q, cds_d;
  logic            ref_q, ref_d;

  assign timer_run  = (state_q == ST_EVAL);
  assign conv_valid = (state_q == ST_CONV);
  assign conv_ref   = conv_valid && ref_q;
  assign busy       = (state_q != ST_IDLE);

  for (genvar g = 0; g < N; g++) begin : g_sel
    assign node_sel[g] = timer_run && (node_q == IDX_W'(g));
  end

  always_comb begin
    state_d   = state_q;
    node_d    = node_q;
    cds_d     = cds_q;
    ref_d     = ref_q;
    load      = 1'b0;
    load_code = CODE_W'(node_q);
    load_sat  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_EVAL;
          node_d  = '0;
          cds_d   = cds_en;
        end
      end
      ST_EVAL: begin
        if (settle_done) begin
          if (cmp_pass) begin
            load    = 1'b1;
            state_d = ST_CONV;
            ref_d   = cds_q && (node_q == '0);
          end else if (node_q == LAST) begin
            load     = 1'b1;
            load_sat = 1'b1;
            state_d  = ST_CONV;
            ref_d    = 1'b0;
          end else begin
            node_d = node_q + 1'b1;
          end
        end
      end
      ST_CONV: begin
        if (conv_ready) begin
          if (ref_q) ref_d = 1'b0;
          else state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      node_q  <= '0;
      cds_q   <= 1'b0;
      ref_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      node_q  <= node_d;
      cds_q   <= cds_d;
      ref_q   <= ref_d;
    end
  end
endmodule

// File: rtl/gainrange_seq.sv
module gainrange_seq
  import gr_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                cds_en_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  input  logic                cmp_pass_i,
  output logic [NODES-1:0]    node_sel_o,
  output logic                conv_valid_o,
  input  logic                conv_ready_i,
  output logic                conv_ref_o,
  output logic [CODE_W-1:0]   range_code_o,
  output logic                range_sat_o,
  output logic                busy_o
);
  logic              timer_run, settle_done, load, load_sat;
  logic [CODE_W-1:0] load_code;

  gr_settle_timer #(.W(SETTLE_W)) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (timer_run),
    .limit (settle_cycles_i),
    .done  (settle_done)
  );

  gr_seq_fsm #(.N(NODES)) i_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_i),
    .cds_en      (cds_en_i),
    .cmp_pass    (cmp_pass_i),
    .settle_done (settle_done),
    .conv_ready  (conv_ready_i),
    .timer_run   (timer_run),
    .node_sel    (node_sel_o),
    .conv_valid  (conv_valid_o),
    .conv_ref    (conv_ref_o),
    .busy        (busy_o),
    .load        (load),
    .load_code   (load_code),
    .load_sat    (load_sat)
  );

  gr_range_latch #(.CODE_W(CODE_W)) i_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_code (load_code),
    .load_sat  (load_sat),
    .code      (range_code_o),
    .sat       (range_sat_o)
  );
endmodule

// File: rtl/gr_seq_checker.sv
module gr_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [2:0] node_sel_o,
  input logic       conv_valid_o,
  input logic       conv_ready_i,
  input logic       conv_ref_o,
  input logic [1:0] range_code_o,
  input logic       range_sat_o,
  input logic       busy_o
);
  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(node_sel_o));

  p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    range_code_o != 2'b11);

  p_sat_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    range_sat_o |-> range_code_o == 2'b10);

  p_ref_diode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid_o && conv_ref_o) |-> range_code_o == 2'b00);

  p_valid_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid_o && !conv_ready_i) |=>
      (conv_valid_o && $stable(conv_ref_o) && $stable(range_code_o)));

  p_busy_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid_o || (node_sel_o != 3'b000)) |-> busy_o);

  p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && node_sel_o == 3'b001));

  p_sel_quiet_conv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid_o |-> node_sel_o == 3'b000);
endmodule

bind gainrange_seq gr_seq_checker i_gr_seq_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .node_sel_o   (node_sel_o),
  .conv_valid_o (conv_valid_o),
  .conv_ready_i (conv_ready_i),
  .conv_ref_o   (conv_ref_o),
  .range_code_o (range_code_o),
  .range_sat_o  (range_sat_o),
  .busy_o       (busy_o)
);

// File: tb/test_gainrange_seq.sv
`timescale 1ns/1ps
module test_gainrange_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       cds_en_i = 1'b0;
  logic [7:0] settle_cycles_i = 8'd0;
  logic       cmp_pass_i = 1'b0;
  logic [2:0] node_sel_o;
  logic       conv_valid_o;
  logic       conv_ready_i = 1'b0;
  logic       conv_ref_o;
  logic [1:0] range_code_o;
  logic       range_sat_o;
  logic       busy_o;

  int n_checks = 0;
  int n_fail   = 0;

  // stimulus knobs
  logic [2:0] mask = 3'b000;
  bit         invert_early = 1'b0;
  int         ready_delay = 0;
  int         wc = 0;

  // reference model state
  int m_st = 0, m_node = 0, m_cnt = 0, m_ref = 0, m_code = 0, m_sat = 0, m_cds = 0;

  always #2.5 clk = ~clk;

  gainrange_seq #(.SETTLE_W(8)) i_gainrange_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cds_en_i(cds_en_i),
    .settle_cycles_i(settle_cycles_i), .cmp_pass_i(cmp_pass_i),
    .node_sel_o(node_sel_o), .conv_valid_o(conv_valid_o),
    .conv_ready_i(conv_ready_i), .conv_ref_o(conv_ref_o),
    .range_code_o(range_code_o), .range_sat_o(range_sat_o), .busy_o(busy_o)
  );

  task automatic check(input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  // behavioural reference model, advanced on every edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_node = 0; m_cnt = 0; m_ref = 0; m_code = 0; m_sat = 0; m_cds = 0;
    end else begin
      case (m_st)
        0: if (start_i) begin m_st = 1; m_node = 0; m_cnt = 0; m_cds = int'(cds_en_i); end
        1: begin
          if (m_cnt == int'(settle_cycles_i)) begin
            if (mask[m_node]) begin
              m_code = m_node; m_sat = 0; m_st = 2;
              m_ref = (m_cds == 1 && m_node == 0) ? 1 : 0;
            end else if (m_node == 2) begin
              m_code = 2; m_sat = 1; m_st = 2; m_ref = 0;
            end else begin
              m_node++; m_cnt = 0;
            end
          end else m_cnt++;
        end
        default: if (conv_ready_i) begin
          if (m_ref == 1) m_ref = 0; else m_st = 0;
        end
      endcase
    end
  end

  // comparator and converter models, driven away from the active edge
  always @(negedge clk) begin
    if (m_st == 1) begin
      if (m_cnt == int'(settle_cycles_i)) cmp_pass_i <= mask[m_node];
      else cmp_pass_i <= invert_early ? !mask[m_node] : mask[m_node];
    end else cmp_pass_i <= invert_early;
    if (!conv_valid_o) begin wc = 0; conv_ready_i <= 1'b0; end
    else if (wc < ready_delay) begin wc++; conv_ready_i <= 1'b0; end
    else begin wc = 0; conv_ready_i <= 1'b1; end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(int'(busy_o), (m_st != 0) ? 1 : 0, "R8 busy");
      check(int'(node_sel_o), (m_st == 1) ? (1 << m_node) : 0, "R2 node_sel");
      check(int'(conv_valid_o), (m_st == 2) ? 1 : 0, "R7 conv_valid");
      check(int'(conv_ref_o), (m_st == 2 && m_ref == 1) ? 1 : 0, "R6 conv_ref");
      check(int'(range_code_o), m_code, "R3 R9 range_code");
      check(int'(range_sat_o), m_sat, "R4 R9 range_sat");
    end
  end

  task automatic run(input logic [2:0] msk, input bit cds, input int settle,
                     input int rdly, input bit inv, input bit hold_start);
    @(negedge clk);
    mask = msk; cds_en_i = cds; settle_cycles_i = 8'(settle);
    ready_delay = rdly; invert_early = inv;
    start_i = 1'b1;
    @(negedge clk);
    start_i = hold_start;
    while (busy_o) @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    check(int'(busy_o), 0, "R8 start during busy ignored");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(int'(busy_o), 0, "R1 busy");
    check(int'(node_sel_o), 0, "R1 node_sel");
    check(int'(conv_valid_o), 0, "R1 conv_valid");
    check(int'(conv_ref_o), 0, "R1 conv_ref");
    check(int'(range_code_o), 0, "R1 code");
    check(int'(range_sat_o), 0, "R1 sat");

    run(3'b001, 1'b0, 2, 0, 1'b0, 1'b0);   // R3 diode, no double read
    run(3'b001, 1'b1, 0, 0, 1'b0, 1'b0);   // R6 diode with double read
    run(3'b010, 1'b1, 3, 1, 1'b0, 1'b0);   // R6 no double read off diode
    run(3'b100, 1'b0, 1, 0, 1'b0, 1'b0);   // R3 large capacitor
    run(3'b000, 1'b0, 2, 2, 1'b0, 1'b0);   // R4 saturation
    run(3'b110, 1'b1, 0, 0, 1'b0, 1'b0);   // R3 first pass wins
    run(3'b101, 1'b0, 4, 0, 1'b1, 1'b0);   // R5 early comparator ignored
    run(3'b000, 1'b1, 3, 0, 1'b1, 1'b0);   // R5 R4 early pass ignored
    run(3'b011, 1'b1, 1, 3, 1'b0, 1'b1);   // R7 R8 back-pressure, start held
    run(3'b001, 1'b1, 2, 2, 1'b1, 1'b1);   // R6 R8 double read, start held
    run(3'b010, 1'b0, 255, 0, 1'b0, 1'b0); // R2 long settle window
    finish_run();
  end
endmodule